// File: doc/BRIEF.md
# Grouped Down-Counter Timer Unit

This block puts two or three down-counting timer channels behind a single register window on a simple word-addressed bus. Two shared registers sit at the bottom of the window. The run register holds one enable bit per channel. The output-control register holds a single bit that drives a pin. Each channel's registers follow at a fixed base. An access that lands inside a channel's window reaches that channel at its offset minus the base. A build parameter decides whether the third channel, which is the one with a capture register, exists. Another parameter decides whether the output-control register exists.

A running channel counts down by one on every clock. When it is at zero, the next count loads it from its reload register and sets its underflow flag. Each channel drives its own interrupt line. The line is high while the channel's underflow flag and its interrupt-enable bit are both set. An access to a location that is not backed by a register raises the error output for one cycle. Such an access changes no state, and a read of it returns zero. Read data and the error output are registered: they appear in the cycle after the access.

Top module: `tmr_group`

## Requirements
- R1: After synchronous reset, bus_rdata, bus_err, irq_o and outctl_o are 0, the run register reads 0, every reload and count register reads all ones (CNT_W bits), and every control register reads 0.
- R2: The run register is at byte offset 0x04. Bit c enables channel c, and only bits for channels that exist are stored. A read returns the stored bits, with zeros above them.
- R3: In every clock in which a channel is enabled, its count goes down by one. If the count is 0, it instead takes the reload value and the underflow flag is set, unless the count register is written in that cycle.
- R4: A disabled channel keeps its count. Enabling it again resumes counting from that value. Writing the run register with an unchanged value has no effect on any counter.
- R5: Channel bases are 0x08, 0x14 and 0x20. Relative offsets are 0x0 for reload, 0x4 for count and 0x8 for control. A count write takes effect at once and overrides the count step in the same cycle.
- R6: Control bit 0 is interrupt enable and bit 1 is the underflow flag. Writing 0 to bit 1 clears the flag and writing 1 leaves it, but an underflow in the same cycle wins. irq_o[c] equals flag AND enable of channel c.
- R7: With THREE_CH=1, channel 2 also has a CNT_W-bit capture register at relative offset 0xC (byte 0x2C) that can be written and read back. Channels 0 and 1 have none.
- R8: With HAS_OUTCTL=1, offset 0x00 stores only bit 0 of the written word, reads it back and drives outctl_o. With HAS_OUTCTL=0, any access there flags an error and reads 0.
- R9: With THREE_CH=0, any access at 0x20 or above flags an error and reads 0. Writing the run register with bit 2 set flags an error, while bits 0 and 1 still take effect.
- R10: Offsets beyond the last register (0x30 and up with three channels) and any address with bits [1:0] not zero flag an error. Such an access reads 0 and changes no state. bus_err and bus_rdata are valid in the cycle after the access, and bus_err is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, 0 for writes and errors |
| bus_err | output | 1 | Registered one-cycle error pulse |
| irq_o | output | 2 or 3 | Per-channel interrupt (3 when THREE_CH=1) |
| outctl_o | output | 1 | Output-control bit |

## Verification
The bench targets the points where the window bases are unequal: the last word of channel 0 next to the first word of channel 1, and the capture word at 0x2C next to the undefined word 0x30. A decoder with a wrong base or span would read the neighbour's register or flag a valid word. Stopping and restarting a channel mid-count, and rewriting the same run value, expose a design that reloads on enable or restarts on every write. A second instance built with two channels and no output-control register is driven with the same accesses. A design that ignored the build options would answer at 0x00 or 0x20 without an error, or would drop bits 0 and 1 when bit 2 is refused.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W    = 32;
  localparam int W_OUTCTL  = 0;
  localparam int W_RUN     = 1;
  localparam int CTRL_IE   = 0;
  localparam int CTRL_UF   = 1;

  typedef enum logic [1:0] {
    REL_RELOAD = 2'd0,
    REL_COUNT  = 2'd1,
    REL_CTRL   = 2'd2,
    REL_CAPT   = 2'd3
  } rel_e;

  // word index of each channel's first register
  function automatic int chan_base_w(input int c);
    return 2 + 3 * c;
  endfunction

  // number of words in a channel window; channel 2 adds the capture word
  function automatic int chan_span_w(input int c);
    return (c == 2) ? 4 : 3;
  endfunction
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NCH        = 3,
  parameter bit HAS_OUTCTL = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_outctl,
  output logic              hit_run,
  output logic [NCH-1:0]    hit_ch,
  output rel_e              rel,
  output logic              bad
);
  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0] w;
  logic            aligned;

  assign w       = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    hit_outctl = aligned && HAS_OUTCTL && (int'(w) == W_OUTCTL);
    hit_run    = aligned && (int'(w) == W_RUN);
    hit_ch     = '0;
    rel        = REL_RELOAD;
    for (int c = 0; c < NCH; c++) begin
      if (aligned && int'(w) >= chan_base_w(c) &&
          int'(w) < chan_base_w(c) + chan_span_w(c)) begin
        hit_ch[c] = 1'b1;
        rel       = rel_e'(2'(int'(w) - chan_base_w(c)));
      end
    end
    bad = !(hit_outctl || hit_run || (|hit_ch));
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter bit CAPT  = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             sel,
  input  logic             we,
  input  rel_e             rel,
  input  logic [CNT_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic             irq_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int PAD = DATA_W - CNT_W;

  logic [CNT_W-1:0] reload_q, cnt_q, capt_q;
  logic             ie_q, uf_q;
  logic             wr, wr_cnt, wr_ctrl, wrap;

  assign wr      = sel && we;
  assign wr_cnt  = wr && (rel == REL_COUNT);
  assign wr_ctrl = wr && (rel == REL_CTRL);
  assign wrap    = run && (cnt_q == '0) && !wr_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '1;
      cnt_q    <= '1;
      ie_q     <= 1'b0;
      uf_q     <= 1'b0;
    end else begin
      if (wr && rel == REL_RELOAD) reload_q <= wdata;
      if (wr_cnt)         cnt_q <= wdata;
      else if (wrap)      cnt_q <= reload_q;
      else if (run)       cnt_q <= cnt_q - 1'b1;
      if (wr_ctrl) ie_q <= wdata[CTRL_IE];
      if (wrap)          uf_q <= 1'b1;
      else if (wr_ctrl)  uf_q <= uf_q & wdata[CTRL_UF];
    end
  end

  generate
    if (CAPT) begin : g_capt
      always_ff @(posedge clk) begin
        if (rst) capt_q <= '0;
        else if (wr && rel == REL_CAPT) capt_q <= wdata;
      end
    end else begin : g_nocapt
      assign capt_q = '0;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    case (rel)
      REL_RELOAD: rdata = {{PAD{1'b0}}, reload_q};
      REL_COUNT:  rdata = {{PAD{1'b0}}, cnt_q};
      REL_CTRL:   rdata = {{(DATA_W-2){1'b0}}, uf_q, ie_q};
      REL_CAPT:   rdata = {{PAD{1'b0}}, capt_q};
      default:    rdata = '0;
    endcase
  end

  assign irq_o = ie_q & uf_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_group.sv
module tmr_group
  import tmr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 16,
  parameter bit THREE_CH   = 1'b1,
  parameter bit HAS_OUTCTL = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_sel,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  output logic                          bus_err,
  output logic [(THREE_CH ? 3 : 2)-1:0] irq_o,
  output logic                          outctl_o
);
  localparam int NCH = THREE_CH ? 3 : 2;

  logic              hit_outctl, hit_run, bad;
  logic [NCH-1:0]    hit_ch;
  rel_e              rel;
  logic [NCH-1:0]    start_q;
  logic              outctl_q;
  logic [DATA_W-1:0] ch_rd [NCH];
  logic [CNT_W-1:0]  ch_cnt [NCH];
  logic [CNT_W-1:0]  ch0_cnt;
  logic [DATA_W-1:0] rd_mux;
  logic              err_d, run_bad;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata;

  tmr_decode #(.ADDR_W(ADDR_W), .NCH(NCH), .HAS_OUTCTL(HAS_OUTCTL)) u_dec (
    .addr(bus_addr), .hit_outctl(hit_outctl), .hit_run(hit_run),
    .hit_ch(hit_ch), .rel(rel), .bad(bad)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      tmr_chan #(.CNT_W(CNT_W), .CAPT(c == 2)) u_ch (
        .clk(clk), .rst(rst), .run(start_q[c]),
        .sel(bus_sel && hit_ch[c]), .we(bus_we), .rel(rel),
        .wdata(bus_wdata[CNT_W-1:0]), .rdata(ch_rd[c]),
        .irq_o(irq_o[c]), .cnt_o(ch_cnt[c])
      );
    end
  endgenerate

  assign ch0_cnt = ch_cnt[0];

  // a run bit for a channel that is not built is refused
  assign run_bad = (NCH < 3) && bus_we && hit_run && bus_wdata[2];
  assign err_d   = bus_sel && (bad || run_bad);

  always_comb begin
    rd_mux = '0;
    if (hit_outctl) rd_mux[0] = outctl_q;
    if (hit_run)    rd_mux[NCH-1:0] = start_q;
    for (int c = 0; c < NCH; c++)
      if (hit_ch[c]) rd_mux = ch_rd[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q   <= '0;
      outctl_q  <= 1'b0;
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err   <= err_d;
      bus_rdata <= (bus_sel && !bus_we && !err_d) ? rd_mux : '0;
      if (bus_sel && bus_we && hit_run)    start_q  <= bus_wdata[NCH-1:0];
      if (bus_sel && bus_we && hit_outctl) outctl_q <= bus_wdata[0];
    end
  end

  assign outctl_o = outctl_q;
endmodule

// File: rtl/tmr_group_chk.sv
module tmr_group_chk #(
  parameter int ADDR_W = 8,
  parameter int NCH    = 3,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_err,
  input logic [NCH-1:0]    run_q,
  input logic [CNT_W-1:0]  cnt0
);
  // R10: an error pulse only follows a real access
  p_err_follows_access_r10: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_sel));

  // R10: a flagged access returns zero data
  p_err_zero_data_r10: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (bus_rdata == 32'h0));

  // R2: a run register write lands in the enables
  p_run_write_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == ADDR_W'(4)) |=> (run_q == $past(bus_wdata[NCH-1:0])));

  // R4: a stopped channel 0 holds its count while no write occurs
  p_stopped_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (!run_q[0] && !(bus_sel && bus_we)) |=> $stable(cnt0));

  // R3: a running channel 0 with a nonzero count moves every cycle
  p_running_moves_r3: assert property (@(posedge clk) disable iff (rst)
    (run_q[0] && cnt0 != '0 && !(bus_sel && bus_we)) |=> (cnt0 == $past(cnt0) - 1'b1));
endmodule

bind tmr_group tmr_group_chk #(.ADDR_W(ADDR_W), .NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
  .run_q(start_q), .cnt0(ch0_cnt)
);

// File: tb/test_tmr_group.sv
module test_tmr_group;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1, sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd, rd2;
  logic        err, err2, oc, oc2;
  logic [2:0]  irq;
  logic [1:0]  irq2;

  tmr_group i_tmr_group (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wd), .bus_rdata(rd), .bus_err(err), .irq_o(irq), .outctl_o(oc));

  tmr_group #(.THREE_CH(1'b0), .HAS_OUTCTL(1'b0)) i_tmr_group_2ch (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wd), .bus_rdata(rd2), .bus_err(err2), .irq_o(irq2), .outctl_o(oc2));

  int    n_tests = 0, n_fail = 0;
  string cur_req = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference of the three-channel instance
  logic [15:0] m_rel [3];
  logic [15:0] m_cnt [3];
  logic [15:0] m_cap;
  logic        m_ie [3];
  logic        m_uf [3];
  logic [2:0]  m_start;
  logic        m_oc;
  logic [31:0] e_rd;
  logic        e_err;
  bit          m_on = 0;

  always @(posedge clk) begin
    int w, c, r;
    logic bad;
    logic [31:0] rv;
    w = int'(addr[7:2]); c = -1; r = 0; bad = 0; rv = 0;
    if (rst) begin
      for (int k = 0; k < 3; k++) begin
        m_rel[k] = 16'hFFFF; m_cnt[k] = 16'hFFFF; m_ie[k] = 0; m_uf[k] = 0;
      end
      m_cap = 0; m_start = 0; m_oc = 0; e_rd = 0; e_err = 0; m_on = 1;
    end else begin
      if (addr[1:0] != 2'b00) bad = 1;
      else if (w == 0) rv = {31'b0, m_oc};
      else if (w == 1) rv = {29'b0, m_start};
      else if (w >= 2 && w < 5)  begin c = 0; r = w - 2; end
      else if (w >= 5 && w < 8)  begin c = 1; r = w - 5; end
      else if (w >= 8 && w < 12) begin c = 2; r = w - 8; end
      else bad = 1;
      if (c >= 0) begin
        case (r)
          0: rv = {16'b0, m_rel[c]};
          1: rv = {16'b0, m_cnt[c]};
          2: rv = {30'b0, m_uf[c], m_ie[c]};
          default: rv = {16'b0, m_cap};
        endcase
      end
      e_err = sel && bad;
      e_rd  = (sel && !we && !bad) ? rv : 32'h0;
      for (int k = 0; k < 3; k++) begin
        bit hitk;
        hitk = sel && we && !bad && (c == k);
        if (hitk && r == 2) begin m_ie[k] = wd[0]; m_uf[k] = m_uf[k] & wd[1]; end
        if (hitk && r == 1) m_cnt[k] = wd[15:0];
        else if (m_start[k]) begin
          if (m_cnt[k] == 0) begin m_cnt[k] = m_rel[k]; m_uf[k] = 1; end
          else m_cnt[k] = m_cnt[k] - 1;
        end
        if (hitk && r == 0) m_rel[k] = wd[15:0];
        if (hitk && r == 3) m_cap = wd[15:0];
      end
      if (sel && we && !bad && w == 1) m_start = wd[2:0];
      if (sel && we && !bad && w == 0) m_oc = wd[0];
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (m_on) begin
      check(rd == e_rd, cur_req, "rdata", rd, e_rd);
      check(err == e_err, cur_req, "err", {31'b0, err}, {31'b0, e_err});
      check(oc == m_oc, "R8", "outctl_o", {31'b0, oc}, {31'b0, m_oc});
      for (int k = 0; k < 3; k++)
        check(irq[k] == (m_uf[k] & m_ie[k]), "R6", "irq_o", {31'b0, irq[k]},
              {31'b0, m_uf[k] & m_ie[k]});
    end
  end

  task automatic acc(input bit w_en, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = w_en; addr = a; wd = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; addr = '0; wd = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1";
    acc(0, 8'h08, 0); acc(0, 8'h0C, 0); acc(0, 8'h10, 0); acc(0, 8'h04, 0);
    acc(0, 8'h2C, 0);
    check(irq2 == 2'b00 && oc2 == 1'b0, "R1", "2ch outputs", {29'b0, oc2, irq2}, 0);

    cur_req = "R5";
    acc(1, 8'h08, 5); acc(1, 8'h0C, 3); acc(1, 8'h10, 1);
    acc(1, 8'h14, 2); acc(1, 8'h18, 7); acc(1, 8'h1C, 1);
    acc(0, 8'h08, 0); acc(0, 8'h10, 0); acc(0, 8'h14, 0); acc(0, 8'h18, 0);

    cur_req = "R3";
    acc(1, 8'h04, 1); idle(12); acc(0, 8'h0C, 0); acc(0, 8'h10, 0);

    cur_req = "R6";
    acc(1, 8'h10, 1); idle(2); acc(1, 8'h10, 0); idle(8);
    acc(1, 8'h10, 3); acc(0, 8'h10, 0);

    cur_req = "R4";
    acc(1, 8'h04, 3); idle(3); acc(1, 8'h04, 2); idle(4);
    acc(0, 8'h0C, 0); acc(0, 8'h0C, 0);
    acc(1, 8'h04, 2); acc(0, 8'h18, 0); acc(1, 8'h04, 3); idle(5);
    acc(1, 8'h0C, 16'h0100); acc(0, 8'h0C, 0);

    cur_req = "R7";
    acc(1, 8'h2C, 32'h0000ABCD); acc(0, 8'h2C, 0);
    acc(1, 8'h20, 4); acc(1, 8'h24, 2); acc(1, 8'h28, 1); acc(1, 8'h04, 7);
    idle(10); acc(0, 8'h24, 0);

    cur_req = "R8";
    acc(1, 8'h00, 32'hFFFF_FFFE); acc(0, 8'h00, 0);
    acc(1, 8'h00, 32'hFFFF_FFFF);
    check(err2 == 1'b1 && oc2 == 1'b0, "R8", "2ch outctl write refused", {30'b0, err2, oc2}, 32'h2);
    acc(0, 8'h00, 0);
    check(err2 == 1'b1 && rd2 == 0, "R8", "2ch outctl read", rd2, 0);

    cur_req = "R9";
    acc(0, 8'h20, 0);
    check(err2 == 1'b1 && rd2 == 0, "R9", "2ch read 0x20", {31'b0, err2}, 1);
    acc(1, 8'h28, 1);
    check(err2 == 1'b1, "R9", "2ch write 0x28", {31'b0, err2}, 1);
    acc(1, 8'h04, 7);
    check(err2 == 1'b1, "R9", "2ch run bit2", {31'b0, err2}, 1);
    acc(0, 8'h04, 0);
    check(err2 == 1'b0 && rd2 == 32'h3, "R9", "2ch run readback", rd2, 32'h3);
    acc(0, 8'h1C, 0);
    check(err2 == 1'b0, "R9", "2ch last ch1 word", {31'b0, err2}, 0);

    cur_req = "R10";
    acc(0, 8'h30, 0); acc(0, 8'hFC, 0); acc(1, 8'h40, 32'hFFFF);
    acc(0, 8'h09, 0); acc(1, 8'h0D, 0); idle(1); acc(0, 8'h0C, 0);

    cur_req = "R2";
    acc(0, 8'h04, 0); acc(1, 8'h04, 32'hFFFF_FFF8); acc(0, 8'h04, 0);
    idle(3); acc(0, 8'h0C, 0);

    idle(2);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule